// File: doc/BRIEF.md
# BCD calendar timekeeping counter

This block holds the time of day and the calendar as seven packed-BCD byte registers: seconds, minutes, hour, date, month, day of week and a two-digit year. Each one-second tick advances the seconds. Rollovers ripple upward through minutes, hours, date, month and year in the same cycle. Day of week advances on every date change. Month lengths follow the calendar, and February has 29 days when the two-digit year is a multiple of four.

Control flags share bytes with the BCD fields. A freeze flag sits in the top bit of the seconds byte. The hour byte has a format-select bit, and a second bit in that byte is either the afternoon flag or the upper tens bit, depending on the format. A serial interface block writes any register through a one-hot strobe vector and a shared data byte. All seven registers are always presented as registered parallel outputs.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the outputs read seconds 00, minutes 00, hour 00 (24-hour format), date 01, month 01, day of week 1 and year 00, with the freeze flag clear.
- R2: Seconds and minutes count 00 to 59 in BCD, with tens in bits 6:4 and ones in bits 3:0. A tick at seconds 59 gives seconds 00 and advances minutes. Minutes 59 rolling over advances the hour.
- R3: Bit 7 of the seconds byte is the freeze flag. While it is 1, ticks change no register and the flag reads back as 1. Writing seconds with bit 7 at 0 resumes counting.
- R4: Hour bit 7 at 0 selects 24-hour format. Bits 5:0 then hold BCD 00 to 23, and 23 rolling over gives 00 and advances the date.
- R5: Hour bit 7 at 1 selects 12-hour format. Bits 4:0 hold BCD 1 to 12 and bit 5 is the afternoon flag (1 = PM). Going from 11 to 12 inverts bit 5, 12 is followed by 01 with bit 5 kept, and 11 PM to 12 AM advances the date. Bit 7 is unchanged by counting.
- R6: Date counts from 01 to the month length: 31 for months 01, 03, 05, 07, 08, 10 and 12; 30 for months 04, 06, 09 and 11; 29 for February when the year's value is divisible by 4, otherwise 28. After the last day the date returns to 01 and the month advances.
- R7: Month 12 rolling over gives 01 and advances the year. Year 99 rolls over to 00.
- R8: Day of week counts 1 to 7 and advances on every date advance, with 7 followed by 1.
- R9: Strobe bit 0 writes seconds, bit 1 minutes, bit 2 hour, bit 3 date, bit 4 month, bit 5 day of week and bit 6 year. The written value shows on the outputs after the next clock edge and wins over a tick in the same cycle.
- R10: Unused bits read 0 after any write: minutes bit 7, hour bit 6, date bits 7:6, month bits 7:5 and day-of-week bits 7:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second advance pulse, one clock wide |
| wr_stb | input | 7 | One-hot register write strobes (index order in R9) |
| wr_data | input | 8 | Write data shared by all strobes |
| seconds_q | output | 8 | Freeze flag and BCD seconds |
| minutes_q | output | 8 | BCD minutes |
| hours_q | output | 8 | Format bit, PM/tens bit and BCD hour |
| date_q | output | 8 | BCD date |
| month_q | output | 8 | BCD month |
| dow_q | output | 8 | Day of week 1 to 7 |
| year_q | output | 8 | BCD two-digit year |

## Verification
The bench uses the default 8-bit register width and the fixed seven-register layout. It presets values next to each rollover through the write strobes, so no boundary needs long runs of ticks. With that, it sweeps every seconds and minutes value, every hour in both formats and with both PM settings, every day of week, and the last two days of every month across leap years, non-leap years and the 99-to-00 year wrap. Freezing, a write and a tick in the same cycle, and the masking of unused bits are checked directly at the outputs.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W = 8;
  localparam int NREG   = 7;

  localparam int IDX_SEC   = 0;
  localparam int IDX_MIN   = 1;
  localparam int IDX_HOUR  = 2;
  localparam int IDX_DATE  = 3;
  localparam int IDX_MONTH = 4;
  localparam int IDX_DOW   = 5;
  localparam int IDX_YEAR  = 6;

  // Add one to a two-digit packed BCD value.
  function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
    logic [BYTE_W-1:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // A two-digit BCD year is a leap year when its value is a multiple of four.
  function automatic logic bcd_leap(input logic [BYTE_W-1:0] y);
    logic [BYTE_W-1:0] bin;
    bin = ({4'd0, y[7:4]} * 8'd10) + {4'd0, y[3:0]};
    return (bin[1:0] == 2'b00);
  endfunction
endpackage

// File: rtl/rtc_month_len.sv
module rtc_month_len
  import rtc_pkg::*;
(
  input  logic [BYTE_W-1:0] month_i,
  input  logic [BYTE_W-1:0] year_i,
  output logic [BYTE_W-1:0] last_date_o
);
  logic leap;
  assign leap = bcd_leap(year_i);

  always_comb begin
    case (month_i)
      8'h02:                      last_date_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_date_o = 8'h30;
      default:                    last_date_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_pkg::*;
#(
  parameter logic [BYTE_W-1:0] MIN_VAL = 8'h00,
  parameter logic [BYTE_W-1:0] MASK    = 8'hFF,
  parameter logic [BYTE_W-1:0] RST_VAL = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] last_val,
  output logic [BYTE_W-1:0] q,
  output logic              at_last
);
  assign at_last = (q == last_val);

  always_ff @(posedge clk) begin
    if (rst)      q <= RST_VAL;
    else if (wr)  q <= wr_data & MASK;
    else if (adv) q <= at_last ? MIN_VAL : bcd_inc(q);
  end

  AST_FIELD_WRAP: assert property (@(posedge clk) disable iff (rst)
    (adv && !wr && at_last) |=> (q == MIN_VAL)); // R2
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!adv && !wr) |=> $stable(q)); // R3
  AST_FIELD_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr |=> (q == ($past(wr_data) & MASK))); // R9
endmodule

// File: rtl/rtc_hour_field.sv
module rtc_hour_field
  import rtc_pkg::*;
#(
  parameter logic [BYTE_W-1:0] RST_VAL = 8'h00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              wr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] q,
  output logic              day_end
);
  localparam logic [BYTE_W-1:0] HOUR_MASK = 8'hBF;

  logic [BYTE_W-1:0] nxt, inc12, inc24;

  assign inc12 = bcd_inc({3'b000, q[4:0]});
  assign inc24 = bcd_inc({2'b00, q[5:0]});

  always_comb begin
    nxt     = q;
    day_end = 1'b0;
    if (q[7]) begin
      if (q[4:0] == 5'h12) begin
        nxt = {1'b1, 1'b0, q[5], 5'h01};
      end else if (q[4:0] == 5'h11) begin
        nxt     = {1'b1, 1'b0, ~q[5], 5'h12};
        day_end = q[5];
      end else begin
        nxt = {1'b1, 1'b0, q[5], inc12[4:0]};
      end
    end else begin
      if (q[5:0] == 6'h23) begin
        nxt     = 8'h00;
        day_end = 1'b1;
      end else begin
        nxt = {2'b00, inc24[5:0]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      q <= RST_VAL;
    else if (wr)  q <= wr_data & HOUR_MASK;
    else if (adv) q <= nxt;
  end

  AST_HOUR_PM_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    (adv && !wr && q[7] && q[4:0] == 5'h11) |=> (q[5] != $past(q[5]))); // R5
  AST_HOUR_MODE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (adv && !wr) |=> (q[7] == $past(q[7]))); // R5
  AST_HOUR_24_WRAP: assert property (@(posedge clk) disable iff (rst)
    (adv && !wr && !q[7] && q[5:0] == 6'h23) |=> (q == 8'h00)); // R4
  AST_HOUR_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr |=> (q == ($past(wr_data) & HOUR_MASK))); // R9
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_pkg::*;
#(
  parameter int                DW        = BYTE_W,
  parameter int                NR        = NREG,
  parameter logic [BYTE_W-1:0] RST_DATE  = 8'h01,
  parameter logic [BYTE_W-1:0] RST_MONTH = 8'h01,
  parameter logic [BYTE_W-1:0] RST_DOW   = 8'h01,
  parameter logic [BYTE_W-1:0] RST_YEAR  = 8'h00
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic [NR-1:0] wr_stb,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] seconds_q,
  output logic [DW-1:0] minutes_q,
  output logic [DW-1:0] hours_q,
  output logic [DW-1:0] date_q,
  output logic [DW-1:0] month_q,
  output logic [DW-1:0] dow_q,
  output logic [DW-1:0] year_q
);
  logic          halt_q;
  logic [DW-1:0] sec_val, last_date;
  logic          sec_last, min_last, date_last, month_last, year_last, dow_last;
  logic          day_end;
  logic          run, min_adv, hour_adv, day_adv, mon_adv, year_adv;

  assign run      = tick && !halt_q;
  assign min_adv  = run && sec_last;
  assign hour_adv = min_adv && min_last;
  assign day_adv  = hour_adv && day_end;
  assign mon_adv  = day_adv && date_last;
  assign year_adv = mon_adv && month_last;

  always_ff @(posedge clk) begin
    if (rst)                 halt_q <= 1'b0;
    else if (wr_stb[IDX_SEC]) halt_q <= wr_data[DW-1];
  end

  assign seconds_q = {halt_q, sec_val[DW-2:0]};

  rtc_bcd_field #(.MIN_VAL(8'h00), .MASK(8'h7F), .RST_VAL(8'h00)) u_sec (
    .clk(clk), .rst(rst), .adv(run), .wr(wr_stb[IDX_SEC]), .wr_data(wr_data),
    .last_val(8'h59), .q(sec_val), .at_last(sec_last));

  rtc_bcd_field #(.MIN_VAL(8'h00), .MASK(8'h7F), .RST_VAL(8'h00)) u_min (
    .clk(clk), .rst(rst), .adv(min_adv), .wr(wr_stb[IDX_MIN]), .wr_data(wr_data),
    .last_val(8'h59), .q(minutes_q), .at_last(min_last));

  rtc_hour_field #(.RST_VAL(8'h00)) u_hour (
    .clk(clk), .rst(rst), .adv(hour_adv), .wr(wr_stb[IDX_HOUR]), .wr_data(wr_data),
    .q(hours_q), .day_end(day_end));

  rtc_month_len u_len (.month_i(month_q), .year_i(year_q), .last_date_o(last_date));

  rtc_bcd_field #(.MIN_VAL(8'h01), .MASK(8'h3F), .RST_VAL(RST_DATE)) u_date (
    .clk(clk), .rst(rst), .adv(day_adv), .wr(wr_stb[IDX_DATE]), .wr_data(wr_data),
    .last_val(last_date), .q(date_q), .at_last(date_last));

  rtc_bcd_field #(.MIN_VAL(8'h01), .MASK(8'h1F), .RST_VAL(RST_MONTH)) u_month (
    .clk(clk), .rst(rst), .adv(mon_adv), .wr(wr_stb[IDX_MONTH]), .wr_data(wr_data),
    .last_val(8'h12), .q(month_q), .at_last(month_last));

  rtc_bcd_field #(.MIN_VAL(8'h01), .MASK(8'h07), .RST_VAL(RST_DOW)) u_dow (
    .clk(clk), .rst(rst), .adv(day_adv), .wr(wr_stb[IDX_DOW]), .wr_data(wr_data),
    .last_val(8'h07), .q(dow_q), .at_last(dow_last));

  rtc_bcd_field #(.MIN_VAL(8'h00), .MASK(8'hFF), .RST_VAL(RST_YEAR)) u_year (
    .clk(clk), .rst(rst), .adv(year_adv), .wr(wr_stb[IDX_YEAR]), .wr_data(wr_data),
    .last_val(8'h99), .q(year_q), .at_last(year_last));

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (halt_q && wr_stb == '0) |=> ($stable(seconds_q) && $stable(minutes_q) &&
      $stable(hours_q) && $stable(date_q) && $stable(month_q) && $stable(year_q))); // R3
  AST_DOW_FOLLOWS_DATE: assert property (@(posedge clk) disable iff (rst)
    (day_adv && wr_stb == '0 && dow_last) |=> (dow_q == 8'h01)); // R8
  AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (year_adv && wr_stb == '0 && year_last) |=> (year_q == 8'h00)); // R7
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_stb)); // R9
endmodule

// File: tb/rtc_bcd_calendar_tb.sv
module rtc_bcd_calendar_tb;
  localparam int S = 0, MI = 1, H = 2, D = 3, MO = 4, W = 5, Y = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [6:0] wr_stb = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] seconds_q, minutes_q, hours_q, date_q, month_q, dow_q, year_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  rtc_bcd_calendar u_dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_stb(wr_stb), .wr_data(wr_data),
    .seconds_q(seconds_q), .minutes_q(minutes_q), .hours_q(hours_q),
    .date_q(date_q), .month_q(month_q), .dow_q(dow_q), .year_q(year_q));

  function automatic logic [7:0] bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int mlen(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic cyc(input logic t, input logic [6:0] s, input logic [7:0] d);
    tick = t; wr_stb = s; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0; wr_stb = '0; wr_data = '0;
  endtask

  task automatic wr(input int idx, input logic [7:0] d);
    cyc(1'b0, 7'(1 << idx), d);
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(H, h); wr(MI, m); wr(S, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int years [8] = '{0, 1, 2, 3, 12, 26, 96, 99};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset values
    chk("R1 sec", seconds_q, 8'h00);  chk("R1 min", minutes_q, 8'h00);
    chk("R1 hour", hours_q, 8'h00);   chk("R1 date", date_q, 8'h01);
    chk("R1 month", month_q, 8'h01);  chk("R1 dow", dow_q, 8'h01);
    chk("R1 year", year_q, 8'h00);

    // R2 full seconds sweep
    for (int i = 1; i <= 60; i++) begin
      cyc(1'b1, '0, 8'h00);
      chk("R2 sec", seconds_q, bcd(i % 60));
    end
    chk("R2 min carry", minutes_q, 8'h01);

    // R2 full minutes sweep
    for (int m = 0; m < 60; m++) begin
      set_time(8'h05, bcd(m), 8'h59);
      cyc(1'b1, '0, 8'h00);
      chk("R2 min", minutes_q, bcd((m + 1) % 60));
      chk("R2 sec wrap", seconds_q, 8'h00);
      chk("R2 hour carry", hours_q, (m == 59) ? 8'h06 : 8'h05);
    end

    // R4 24-hour sweep
    for (int h = 0; h < 24; h++) begin
      wr(D, 8'h10);
      set_time(bcd(h), 8'h59, 8'h59);
      cyc(1'b1, '0, 8'h00);
      chk("R4 hour", hours_q, bcd((h + 1) % 24));
      chk("R4 date", date_q, (h == 23) ? 8'h11 : 8'h10);
    end

    // R5 12-hour sweep, both halves of the day
    for (int pm = 0; pm < 2; pm++) begin
      for (int h = 1; h <= 12; h++) begin
        int nh, npm;
        nh  = (h == 12) ? 1 : h + 1;
        npm = (h == 11) ? 1 - pm : pm;
        wr(D, 8'h10);
        set_time(8'h80 | 8'(pm << 5) | bcd(h), 8'h59, 8'h59);
        cyc(1'b1, '0, 8'h00);
        chk("R5 hour", hours_q, 8'h80 | 8'(npm << 5) | bcd(nh));
        chk("R5 date", date_q, (h == 11 && pm == 1) ? 8'h11 : 8'h10);
      end
    end

    // R6 R7 month ends across several years
    foreach (years[k]) begin
      for (int m = 1; m <= 12; m++) begin
        int y, dl;
        y  = years[k];
        dl = mlen(m, y);
        wr(Y, bcd(y)); wr(MO, bcd(m)); wr(D, bcd(dl - 1));
        set_time(8'h23, 8'h59, 8'h59);
        cyc(1'b1, '0, 8'h00);
        chk("R6 last day", date_q, bcd(dl));
        set_time(8'h23, 8'h59, 8'h59);
        cyc(1'b1, '0, 8'h00);
        chk("R6 date wrap", date_q, 8'h01);
        chk("R7 month", month_q, bcd(m % 12 + 1));
        chk("R7 year", year_q, (m == 12) ? bcd((y + 1) % 100) : bcd(y));
      end
    end

    // R8 day of week sweep
    for (int d = 1; d <= 7; d++) begin
      wr(MO, 8'h03); wr(D, 8'h05); wr(W, bcd(d));
      set_time(8'h23, 8'h59, 8'h59);
      cyc(1'b1, '0, 8'h00);
      chk("R8 dow", dow_q, (d == 7) ? 8'h01 : bcd(d + 1));
    end

    // R3 freeze
    wr(MI, 8'h20);
    wr(S, 8'hB0);
    repeat (5) cyc(1'b1, '0, 8'h00);
    chk("R3 frozen sec", seconds_q, 8'hB0);
    chk("R3 frozen min", minutes_q, 8'h20);
    wr(S, 8'h59);
    chk("R3 flag cleared", seconds_q, 8'h59);
    cyc(1'b1, '0, 8'h00);
    chk("R3 resumed sec", seconds_q, 8'h00);
    chk("R3 resumed min", minutes_q, 8'h21);

    // R9 write wins over tick
    cyc(1'b1, 7'(1 << S), 8'h12);
    chk("R9 sec write vs tick", seconds_q, 8'h12);
    wr(S, 8'h59);
    cyc(1'b1, 7'(1 << MI), 8'h45);
    chk("R9 min write vs carry", minutes_q, 8'h45);
    chk("R9 sec still ticks", seconds_q, 8'h00);

    // R10 unused bits masked
    wr(MI, 8'hFF); chk("R10 min mask", minutes_q, 8'h7F);
    wr(H, 8'hFF);  chk("R10 hour mask", hours_q, 8'hBF);
    wr(D, 8'hFF);  chk("R10 date mask", date_q, 8'h3F);
    wr(MO, 8'hFF); chk("R10 month mask", month_q, 8'h1F);
    wr(W, 8'hFF);  chk("R10 dow mask", dow_q, 8'h07);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule